// File: doc/BRIEF.md
# Interrupt Source Gateway

This block sits between one external interrupt wire and the core of a platform interrupt controller. It turns the activity on that wire into a single pending request. After that request is claimed, the block holds back any further request until software writes a completion. The completion write has side effects and arrives here as a one-cycle strobe.

The wire is first brought into the clock domain by a synchroniser. A mode input then chooses how the synchronised wire is interpreted:

- **Level mode.** The block raises a request whenever the line is high while it is idle. After a completion, it raises a new request only if the line is still high.
- **Edge mode.** Only rising edges count. This mode also serves message-signalled interrupts, which arrive as single-cycle pulses. Rising edges that arrive while a request is outstanding are tallied in a saturating counter. Each later completion reissues one request until the tally is used up.

The controller core sees a single `req_o` line. It acknowledges that line with `claim_i` once its claim logic has picked this source.

Top module: `irq_gateway`

## Requirements
- R1: While `rst_n` is low and on the first cycle after its release, `req_o` is 0, and the gateway starts idle with no counted edges.
- R2: The raw input passes through a two-flop synchroniser. A change on `irq_raw_i` that is stable before a rising clock edge becomes visible on `req_o` at the third rising edge, counting that edge as the first.
- R3: In level mode (`edge_mode_i` = 0), an idle gateway raises `req_o` whenever the synchronised input is 1.
- R4: Once raised, `req_o` stays 1 until `claim_i` is 1 on a clock edge. At that edge `req_o` falls and the gateway enters service.
- R5: While in service and before a completion, `req_o` stays 0 whatever the raw input does.
- R6: In level mode, a completion (`complete_i` = 1) during service raises `req_o` again at that edge if the synchronised input is 1. Otherwise the gateway returns to idle.
- R7: In edge mode (`edge_mode_i` = 1), rising edges that arrive while a request is pending or in service are counted, saturating at 7. Each completion during service raises `req_o` again while the count is nonzero and decrements it. In level mode the count is held at 0.
- R8: A completion strobe outside service, and a claim strobe while no request is raised, have no effect.
- R9: In edge mode, only a rising edge of the synchronised input starts a request. A line held high gives exactly one request, and a high pulse one clock long gives a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_raw_i | input | 1 | Raw external interrupt wire, asynchronous |
| edge_mode_i | input | 1 | 1 = edge sensing, 0 = level sensing |
| claim_i | input | 1 | One-cycle strobe from the core's claim logic; clears the pending request |
| complete_i | input | 1 | One-cycle strobe from the completion register write |
| req_o | output | 1 | Pending request to the controller core |

## Verification
The bench drives a burst of ten edges during a single service period and then issues completions one at a time. A counter that wraps instead of saturating, or that fails to decrement, would give the wrong number of reissued requests. It also holds the line high through a completion in both modes: a level gateway that drops the request, or an edge gateway that treats the steady level as a new edge, shows up at once. Stray claim and completion strobes are sent while idle and while pending; a design that honours them would lose or duplicate a request. The pipeline latency is checked cycle by cycle, so a missing or extra synchroniser stage is reported.

// File: rtl/irq_gw_pkg.sv
package irq_gw_pkg;

    typedef enum logic [1:0] {
        GW_IDLE    = 2'd0,
        GW_PENDING = 2'd1,
        GW_SERVICE = 2'd2
    } gw_state_e;

    typedef struct packed {
        gw_state_e state;
    } gw_regs_t;

endpackage

// File: rtl/gw_sync.sv
module gw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/gw_edge.sv
module gw_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = level_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/gw_count.sv
module gw_count #(
    parameter int MAX = 7,
    localparam int W  = $clog2(MAX + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    input  logic         dec_i,
    output logic [W-1:0] count_o,
    output logic         avail_o
);
    logic [W-1:0] cnt_d, cnt_q, sum;

    always_comb begin
        sum = cnt_q;
        if (inc_i && (cnt_q != W'(MAX))) sum = cnt_q + W'(1);
        avail_o = (sum != '0);
        cnt_d   = sum;
        if (dec_i && avail_o) cnt_d = sum - W'(1);
        if (clr_i)            cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/irq_gateway.sv
module irq_gateway
    import irq_gw_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int EDGE_MAX    = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_raw_i,
    input  logic edge_mode_i,
    input  logic claim_i,
    input  logic complete_i,
    output logic req_o
);
    localparam int CNT_W = $clog2(EDGE_MAX + 1);

    logic             lvl, rise;
    logic             cnt_inc, cnt_dec, cnt_clr, avail;
    logic [CNT_W-1:0] cnt;
    gw_regs_t         st_d, st_q;
    gw_state_e        cur_state;

    gw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(irq_raw_i), .sync_o(lvl)
    );

    gw_edge u_edge (
        .clk(clk), .rst_n(rst_n), .level_i(lvl), .rise_o(rise)
    );

    gw_count #(.MAX(EDGE_MAX)) u_count (
        .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .inc_i(cnt_inc),
        .dec_i(cnt_dec), .count_o(cnt), .avail_o(avail)
    );

    assign cur_state = st_q.state;

    // edges are tallied only while a request is outstanding
    assign cnt_inc = rise && (st_q.state != GW_IDLE);
    assign cnt_dec = edge_mode_i && (st_q.state == GW_SERVICE) && complete_i;
    assign cnt_clr = !edge_mode_i;

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            GW_IDLE: begin
                if (edge_mode_i ? rise : lvl) st_d.state = GW_PENDING;
            end
            GW_PENDING: begin
                if (claim_i) st_d.state = GW_SERVICE;
            end
            GW_SERVICE: begin
                if (complete_i) begin
                    if (edge_mode_i) st_d.state = avail ? GW_PENDING : GW_IDLE;
                    else             st_d.state = lvl   ? GW_PENDING : GW_IDLE;
                end
            end
            default: st_d.state = GW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{state: GW_IDLE};
        else        st_q <= st_d;
    end

    assign req_o = (st_q.state == GW_PENDING);
endmodule

// File: rtl/gw_checker.sv
module gw_checker
    import irq_gw_pkg::*;
#(
    parameter int CW       = 3,
    parameter int EDGE_MAX = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          claim_i,
    input logic          complete_i,
    input logic          edge_mode_i,
    input logic          req_o,
    input gw_state_e     state_i,
    input logic [CW-1:0] count_i
);
    assert_hold_until_claim_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !claim_i) |=> req_o);

    assert_drop_on_claim_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && claim_i) |=> !req_o);

    assert_quiet_in_service_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == GW_SERVICE && !complete_i) |=> !req_o);

    assert_rearm_only_on_complete_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> $past(state_i == GW_IDLE || complete_i));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count_i <= CW'(EDGE_MAX));

    assert_level_clears_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_mode_i |=> (count_i == '0));
endmodule

bind irq_gateway gw_checker #(.CW(CNT_W), .EDGE_MAX(EDGE_MAX)) u_gw_checker (
    .clk(clk), .rst_n(rst_n), .claim_i(claim_i), .complete_i(complete_i),
    .edge_mode_i(edge_mode_i), .req_o(req_o), .state_i(cur_state), .count_i(cnt)
);

// File: tb/irq_gateway_bench.sv
module irq_gateway_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic raw = 1'b0, mode = 1'b0, claim = 1'b0, complete = 1'b0;
    logic req;
    int   checks = 0, fails = 0;
    bit   done = 0;

    // reference model state, advanced at each rising edge
    logic m_s1 = 0, m_s2 = 0, m_prev = 0;
    int   m_st = 0, m_cnt = 0;

    always #10 clk = ~clk;

    irq_gateway u_irq_gateway (
        .clk(clk), .rst_n(rst_n), .irq_raw_i(raw), .edge_mode_i(mode),
        .claim_i(claim), .complete_i(complete), .req_o(req)
    );

    function automatic int sat_inc(int c, bit r);
        return (r && c < 7) ? c + 1 : c;
    endfunction

    always @(posedge clk) begin
        bit rise;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_st = 0; m_cnt = 0;
        end else begin
            rise = m_s2 && !m_prev;
            case (m_st)
                0: if (mode ? rise : m_s2) m_st = 1;
                1: begin
                    m_cnt = sat_inc(m_cnt, rise);
                    if (claim) m_st = 2;
                end
                default: begin
                    m_cnt = sat_inc(m_cnt, rise);
                    if (complete) begin
                        if (mode) begin
                            if (m_cnt > 0) begin m_cnt = m_cnt - 1; m_st = 1; end
                            else m_st = 0;
                        end else m_st = m_s2 ? 1 : 0;
                    end
                end
            endcase
            if (!mode) m_cnt = 0;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = raw;
        end
    end

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: req_o=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_claim();
        claim = 1; cyc(); claim = 0;
    endtask

    task automatic do_complete();
        complete = 1; cyc(); complete = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1d5e_a7c3));
        cyc(3);
        check("R1 in reset", req, 1'b0);
        rst_n = 1; cyc();
        check("R1 after reset", req, 1'b0);

        // level mode
        raw = 1; cyc(2);
        check("R2 two edges after input", req, 1'b0);
        cyc();
        check("R3 level request at third edge", req, 1'b1);
        cyc(4);
        check("R4 request held", req, 1'b1);
        do_complete();
        check("R8 completion while pending ignored", req, 1'b1);
        do_claim();
        check("R4 claim drops request", req, 1'b0);
        cyc(4);
        check("R5 no request in service", req, 1'b0);
        do_complete();
        check("R6 level still high re-raises", req, 1'b1);
        do_claim(); raw = 0; cyc(4);
        do_complete();
        check("R6 level low returns idle", req, 1'b0);
        do_complete();
        check("R8 completion in idle ignored", req, 1'b0);
        do_claim();
        check("R8 claim in idle ignored", req, 1'b0);
        raw = 1; cyc(3);
        check("R8 state intact after stray strobes", req, 1'b1);
        do_claim(); raw = 0; cyc(4); do_complete(); cyc();
        check("R6 idle after completion", req, 1'b0);

        // edge mode
        mode = 1; cyc(2);
        raw = 1; cyc(); raw = 0; cyc(2);
        check("R9 one-cycle pulse gives request", req, 1'b1);
        do_claim();
        for (int p = 0; p < 10; p++) begin
            raw = 1; cyc(); raw = 0; cyc();
        end
        cyc(3);
        check("R5 no request while edges arrive in service", req, 1'b0);
        for (int k = 0; k < 7; k++) begin
            do_complete();
            check("R7 counted edge reissued", req, 1'b1);
            do_claim();
        end
        do_complete();
        check("R7 saturated count exhausted", req, 1'b0);
        raw = 1; cyc(3);
        check("R9 rising edge request", req, 1'b1);
        do_claim(); cyc(4); do_complete(); cyc(3);
        check("R9 steady high gives no second request", req, 1'b0);
        raw = 0; cyc(3);

        // random phase against the model
        for (int i = 0; i < 4000; i++) begin
            raw      = ($urandom_range(0, 3) == 0) ? ~raw : raw;
            claim    = ($urandom_range(0, 3) == 0);
            complete = ($urandom_range(0, 5) == 0);
            if ($urandom_range(0, 299) == 0) mode = ~mode;
            cyc();
            check(mode ? "R7 random edge mode" : "R6 random level mode", req, m_st == 1);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule